// File: doc/BRIEF.md
# System-Control Wait and Barrier Sequencer

This block sits beside a core's coprocessor register-transfer path. It handles two system operations: wait-for-interrupt and data memory barrier. The core presents the opcode fields of a transfer, a direction flag, its privilege level, the instruction address and a data word. The block recognises the two operations and checks whether the access is allowed. A forbidden access raises an undefined-instruction trap in the same cycle.

A legal wait-for-interrupt stalls the core and signals low power. The stall lasts until any wake source becomes active. Wake sources are an interrupt, a fast interrupt, an imprecise external abort and a debug request. They are not gated by any mask bit.

A legal barrier stalls the core and raises a request to the memory system until that request is acknowledged. Each completion gives a one-cycle done pulse.

For a legal wait, the block captures a return-link value: the instruction address plus eight. A return that subtracts four from the link then resumes at the instruction after the wait.

Top module: `cp_sysop_ctrl`

## Requirements
- R1: After reset, stall, low_power, bar_req, undef_trap and done are low and ret_link is zero.
- R2: The fields op1/crn/crm/op2 are decoded as follows. Wait-for-interrupt is 0/7/0/4. Barrier is 0/7/10/5. Any other encoding causes no trap, no stall and no change to ret_link.
- R3: When either operation is issued as a read (req_write low), undef_trap is high in the same cycle as req_valid. This holds in every privilege mode. The state does not change, so stall stays low on the next cycle.
- R4: A wait-for-interrupt write with req_priv low traps as in R3. A barrier write with req_priv low is legal.
- R5: After a legal wait-for-interrupt write is accepted at a clock edge, stall and low_power are high from that edge on. They stay high while all wake bits are low.
- R6: wake is a level vector: bit 0 is interrupt, bit 1 is fast interrupt, bit 2 is imprecise abort and bit 3 is debug. While low_power is high, any single high bit ends the wait at the next edge. At that edge stall and low_power fall and done is high for exactly one cycle.
- R7: On acceptance of a legal wait-for-interrupt, ret_link takes req_pc + 8 (modulo 2^ADDR_W). It holds that value until the next legal wait.
- R8: After a legal barrier write is accepted, stall and bar_req are high and low_power is low. This lasts until bar_ack is seen at an edge. At that edge stall and bar_req fall and done pulses for one cycle.
- R9: While stall is high, req_valid is ignored: no trap and no change of state or ret_link. The value of req_wdata has no effect on any output.
- R10: wake and bar_ack have no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Coprocessor transfer presented this cycle |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_op2 | input | 3 | Second opcode field |
| req_write | input | 1 | 1 = write to coprocessor, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| req_wdata | input | 32 | Data word (should be zero, ignored) |
| req_pc | input | ADDR_W | Address of the transfer instruction |
| wake | input | WAKE_N | Wake sources, level sensitive |
| bar_ack | input | 1 | Memory-side barrier acknowledge |
| stall | output | 1 | Hold the core pipeline |
| low_power | output | 1 | Core is in low-power wait |
| bar_req | output | 1 | Barrier request to memory side |
| undef_trap | output | 1 | Undefined-instruction trap, same cycle as request |
| done | output | 1 | One-cycle completion pulse |
| ret_link | output | ADDR_W | Return-link value for interrupt entry |

## Verification
Some properties are checked on every cycle:
- low power implies stall;
- a barrier request never coincides with low power;
- any wake bit during the wait, or an acknowledge during a barrier, leads to done on the next cycle;
- done never lasts two cycles;
- no trap is raised while stalled;
- the return link is stable while stalled.

Other behaviours need the directed scenarios in the bench:
- the exact encodings that are recognised;
- the split of privilege rules between the two operations;
- the link arithmetic, including address wrap;
- the fact that unrelated encodings, wake levels in idle and data values change nothing.

// File: rtl/cp_sysop_pkg.sv
package cp_sysop_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SLEEP   = 2'd1,
      ST_BARRIER = 2'd2
   } sysop_state_e;

   typedef struct packed {
      logic [2:0] op1;
      logic [3:0] crn;
      logic [3:0] crm;
      logic [2:0] op2;
   } sysop_enc_t;

   localparam sysop_enc_t ENC_WFI = '{op1: 3'd0, crn: 4'd7, crm: 4'd0,  op2: 3'd4};
   localparam sysop_enc_t ENC_DMB = '{op1: 3'd0, crn: 4'd7, crm: 4'd10, op2: 3'd5};

endpackage

// File: rtl/cp_sysop_decode.sv
module cp_sysop_decode
   import cp_sysop_pkg::*;
(
   input  logic       valid,
   input  sysop_enc_t enc,
   input  logic       write,
   input  logic       priv,
   input  logic       idle,
   output logic       wfi_go,
   output logic       dmb_go,
   output logic       trap
);

   logic hit_wfi;
   logic hit_dmb;
   logic take;
   logic wfi_ok;
   logic dmb_ok;

   always_comb begin
      hit_wfi = (enc == ENC_WFI);
      hit_dmb = (enc == ENC_DMB);
      take    = valid && idle;
      // wait needs write and privilege; barrier needs write only
      wfi_ok  = write && priv;
      dmb_ok  = write;
      wfi_go  = take && hit_wfi && wfi_ok;
      dmb_go  = take && hit_dmb && dmb_ok;
      trap    = take && ((hit_wfi && !wfi_ok) || (hit_dmb && !dmb_ok));
   end

endmodule

// File: rtl/cp_sysop_fsm.sv
module cp_sysop_fsm
   import cp_sysop_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wfi_go,
   input  logic dmb_go,
   input  logic wake_any,
   input  logic bar_ack,
   output logic idle,
   output logic stall,
   output logic low_power,
   output logic bar_req,
   output logic done
);

   sysop_state_e state_q, state_d;
   logic         done_d;

   always_comb begin
      state_d = state_q;
      done_d  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (wfi_go)      state_d = ST_SLEEP;
            else if (dmb_go) state_d = ST_BARRIER;
         end
         ST_SLEEP: begin
            if (wake_any) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
         end
         ST_BARRIER: begin
            if (bar_ack) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= done_d;
      end
   end

   always_comb begin
      idle      = (state_q == ST_IDLE);
      stall     = !idle;
      low_power = (state_q == ST_SLEEP);
      bar_req   = (state_q == ST_BARRIER);
   end

endmodule

// File: rtl/cp_sysop_link.sv
module cp_sysop_link #(
   parameter int ADDR_W      = 32,
   parameter int LINK_OFFSET = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] link
);

   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(LINK_OFFSET);

   logic [ADDR_W-1:0] link_d;

   generate
      if (LINK_OFFSET == 0) begin : g_plain
         assign link_d = pc;
      end else begin : g_add
         assign link_d = pc + OFS;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    link <= '0;
      else if (load) link <= link_d;
   end

endmodule

// File: rtl/cp_sysop_ctrl.sv
module cp_sysop_ctrl
   import cp_sysop_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WAKE_N      = 4,
   parameter int LINK_OFFSET = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op1,
   input  logic [3:0]        req_crn,
   input  logic [3:0]        req_crm,
   input  logic [2:0]        req_op2,
   input  logic              req_write,
   input  logic              req_priv,
   input  logic [31:0]       req_wdata,
   input  logic [ADDR_W-1:0] req_pc,
   input  logic [WAKE_N-1:0] wake,
   input  logic              bar_ack,
   output logic              stall,
   output logic              low_power,
   output logic              bar_req,
   output logic              undef_trap,
   output logic              done,
   output logic [ADDR_W-1:0] ret_link
);

   generate
      if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_addr
         $error("cp_sysop_ctrl: ADDR_W out of range");
      end
      if (WAKE_N < 1) begin : g_bad_wake
         $error("cp_sysop_ctrl: WAKE_N must be at least 1");
      end
      if (LINK_OFFSET < 0) begin : g_bad_ofs
         $error("cp_sysop_ctrl: LINK_OFFSET must not be negative");
      end
   endgenerate

   sysop_enc_t enc;
   logic       idle;
   logic       wfi_go;
   logic       dmb_go;
   logic       wake_any;
   logic       wdata_unused;

   assign enc          = '{op1: req_op1, crn: req_crn, crm: req_crm, op2: req_op2};
   assign wake_any     = |wake;   // no mask gating on any source
   assign wdata_unused = ^req_wdata;

   cp_sysop_decode u_decode (
      .valid  (req_valid),
      .enc    (enc),
      .write  (req_write),
      .priv   (req_priv),
      .idle   (idle),
      .wfi_go (wfi_go),
      .dmb_go (dmb_go),
      .trap   (undef_trap)
   );

   cp_sysop_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wfi_go    (wfi_go),
      .dmb_go    (dmb_go),
      .wake_any  (wake_any),
      .bar_ack   (bar_ack),
      .idle      (idle),
      .stall     (stall),
      .low_power (low_power),
      .bar_req   (bar_req),
      .done      (done)
   );

   cp_sysop_link #(
      .ADDR_W      (ADDR_W),
      .LINK_OFFSET (LINK_OFFSET)
   ) u_link (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (wfi_go),
      .pc    (req_pc),
      .link  (ret_link)
   );

endmodule

// File: rtl/cp_sysop_chk.sv
module cp_sysop_chk #(
   parameter int ADDR_W = 32,
   parameter int WAKE_N = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stall,
   input logic              low_power,
   input logic              bar_req,
   input logic              bar_ack,
   input logic [WAKE_N-1:0] wake,
   input logic              undef_trap,
   input logic              done,
   input logic [ADDR_W-1:0] ret_link
);

   a_r5_lp_implies_stall: assert property (@(posedge clk) disable iff (!rst_n)
      low_power |-> stall);

   a_r8_bar_not_lp: assert property (@(posedge clk) disable iff (!rst_n)
      bar_req |-> (stall && !low_power));

   a_r6_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && (|wake)) |=> (!stall && done));

   a_r8_ack_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_req && bar_ack) |=> (!stall && done));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r9_no_trap_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !undef_trap);

   a_r3_trap_no_state: assert property (@(posedge clk) disable iff (!rst_n)
      undef_trap |=> !stall);

   a_r7_link_held: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(ret_link));

endmodule

bind cp_sysop_ctrl cp_sysop_chk #(
   .ADDR_W (ADDR_W),
   .WAKE_N (WAKE_N)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stall      (stall),
   .low_power  (low_power),
   .bar_req    (bar_req),
   .bar_ack    (bar_ack),
   .wake       (wake),
   .undef_trap (undef_trap),
   .done       (done),
   .ret_link   (ret_link)
);

// File: tb/tb_cp_sysop_ctrl.sv
module tb_cp_sysop_ctrl;

   localparam int AW = 32;
   localparam int WN = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op1 = '0;
   logic [3:0]    req_crn = '0;
   logic [3:0]    req_crm = '0;
   logic [2:0]    req_op2 = '0;
   logic          req_write = 1'b0;
   logic          req_priv = 1'b0;
   logic [31:0]   req_wdata = '0;
   logic [AW-1:0] req_pc = '0;
   logic [WN-1:0] wake = '0;
   logic          bar_ack = 1'b0;
   logic          stall, low_power, bar_req, undef_trap, done;
   logic [AW-1:0] ret_link;

   int n_tests = 0;
   int n_fail  = 0;
   bit ended   = 0;

   always #4 clk = ~clk;   // 125 MHz

   cp_sysop_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op1(req_op1),
      .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2),
      .req_write(req_write), .req_priv(req_priv), .req_wdata(req_wdata),
      .req_pc(req_pc), .wake(wake), .bar_ack(bar_ack), .stall(stall),
      .low_power(low_power), .bar_req(bar_req), .undef_trap(undef_trap),
      .done(done), .ret_link(ret_link)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // drive one request for one cycle; trap sampled before the edge
   task automatic issue(input logic [2:0] o1, input logic [3:0] cn, input logic [3:0] cm,
                        input logic [2:0] o2, input logic wr, input logic pv,
                        input logic [AW-1:0] pc, input logic [31:0] wd, output logic trap);
      @(negedge clk);
      req_valid = 1'b1; req_op1 = o1; req_crn = cn; req_crm = cm; req_op2 = o2;
      req_write = wr; req_priv = pv; req_pc = pc; req_wdata = wd;
      #1 trap = undef_trap;
      @(negedge clk);
      req_valid = 1'b0; req_wdata = '0;
   endtask

   task automatic t_reset();
      check("R1 stall", stall, 0);
      check("R1 low_power", low_power, 0);
      check("R1 bar_req", bar_req, 0);
      check("R1 undef_trap", undef_trap, 0);
      check("R1 done", done, 0);
      check("R1 ret_link", ret_link, 0);
   endtask

   task automatic t_wfi(input int bit_idx, input logic [AW-1:0] pc, input logic [31:0] wd);
      logic tr;
      issue(3'd0, 4'd7, 4'd0, 3'd4, 1'b1, 1'b1, pc, wd, tr);
      check("R5 no trap", tr, 0);
      check("R5 stall", stall, 1);
      check("R5 low_power", low_power, 1);
      check("R7 link", ret_link, 64'(AW'(pc + 32'd8)));
      for (int i = 0; i < 3; i++) @(negedge clk);
      check("R5 still asleep", low_power, 1);
      check("R5 still stalled", stall, 1);
      check("R8 no bar_req in wait", bar_req, 0);
      wake = WN'(1) << bit_idx;
      @(negedge clk);
      wake = '0;
      check("R6 woke", stall, 0);
      check("R6 lp off", low_power, 0);
      check("R6 done", done, 1);
      @(negedge clk);
      check("R6 done one cycle", done, 0);
      check("R7 link held", ret_link, 64'(AW'(pc + 32'd8)));
   endtask

   task automatic t_dmb(input logic pv);
      logic tr;
      issue(3'd0, 4'd7, 4'd10, 3'd5, 1'b1, pv, 32'h2000, 32'hDEAD_BEEF, tr);
      check("R4/R8 no trap", tr, 0);
      check("R8 stall", stall, 1);
      check("R8 bar_req", bar_req, 1);
      check("R8 no low_power", low_power, 0);
      for (int i = 0; i < 2; i++) @(negedge clk);
      check("R8 waiting", bar_req, 1);
      bar_ack = 1'b1;
      @(negedge clk);
      bar_ack = 1'b0;
      check("R8 released", stall, 0);
      check("R8 req dropped", bar_req, 0);
      check("R8 done", done, 1);
      @(negedge clk);
      check("R8 done one cycle", done, 0);
   endtask

   task automatic t_traps();
      logic tr;
      logic [AW-1:0] keep;
      keep = ret_link;
      issue(3'd0, 4'd7, 4'd0, 3'd4, 1'b0, 1'b1, 32'h500, 0, tr);
      check("R3 wfi read priv", tr, 1);
      check("R3 no stall", stall, 0);
      issue(3'd0, 4'd7, 4'd10, 3'd5, 1'b0, 1'b0, 32'h504, 0, tr);
      check("R3 dmb read user", tr, 1);
      check("R3 no stall", stall, 0);
      issue(3'd0, 4'd7, 4'd10, 3'd5, 1'b0, 1'b1, 32'h506, 0, tr);
      check("R3 dmb read priv", tr, 1);
      issue(3'd0, 4'd7, 4'd0, 3'd4, 1'b1, 1'b0, 32'h508, 0, tr);
      check("R4 wfi user write", tr, 1);
      check("R4 no stall", stall, 0);
      check("R4 link untouched", ret_link, keep);
      @(negedge clk);
      check("R3 trap one cycle", undef_trap, 0);
   endtask

   task automatic t_other();
      logic tr;
      logic [AW-1:0] keep;
      keep = ret_link;
      issue(3'd0, 4'd7, 4'd10, 3'd4, 1'b1, 1'b1, 32'h600, 0, tr);
      check("R2 crm10/op2=4 no trap", tr, 0);
      check("R2 no stall", stall, 0);
      issue(3'd1, 4'd7, 4'd0, 3'd4, 1'b0, 1'b1, 32'h604, 0, tr);
      check("R2 op1=1 read no trap", tr, 0);
      check("R2 no stall", stall, 0);
      issue(3'd0, 4'd6, 4'd0, 3'd4, 1'b1, 1'b1, 32'h608, 0, tr);
      check("R2 crn6 no stall", stall, 0);
      check("R2 link untouched", ret_link, keep);
   endtask

   task automatic t_stalled_ignore();
      logic tr;
      issue(3'd0, 4'd7, 4'd0, 3'd4, 1'b1, 1'b1, 32'h700, 32'hFFFF_FFFF, tr);
      check("R9 entered wait", low_power, 1);
      issue(3'd0, 4'd7, 4'd0, 3'd4, 1'b0, 1'b1, 32'h800, 0, tr);
      check("R9 no trap while stalled", tr, 0);
      issue(3'd0, 4'd7, 4'd0, 3'd4, 1'b1, 1'b1, 32'h900, 0, tr);
      check("R9 link not reloaded", ret_link, 32'h708);
      check("R9 still asleep", low_power, 1);
      bar_ack = 1'b1;
      @(negedge clk);
      bar_ack = 1'b0;
      check("R9 ack ignored in wait", low_power, 1);
      wake = 4'b1111;
      @(negedge clk);
      wake = '0;
      check("R6 multi wake", stall, 0);
      @(negedge clk);
   endtask

   task automatic t_idle_ignore();
      wake = 4'b1111; bar_ack = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R10 idle stall", stall, 0);
      check("R10 idle done", done, 0);
      check("R10 idle bar_req", bar_req, 0);
      wake = '0; bar_ack = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      for (int b = 0; b < WN; b++) t_wfi(b, 32'h1000 + 32'(b * 16), 32'h0);
      t_wfi(0, 32'hFFFF_FFFC, 32'h1234_5678);   // wrap case for R7
      t_dmb(1'b1);
      t_dmb(1'b0);
      t_traps();
      t_other();
      t_stalled_ignore();
      t_idle_ignore();
      finish_run();
   end

endmodule